// File: doc/BRIEF.md
# Prescaled Period Timer with Gating

This block is a 16-bit timer/counter for a small register-mapped peripheral space. It counts one of two sources. The first is the system clock passed through a selectable prescaler. The second is rising edges of an external pin, after that pin has been synchronized and prescaled. The count runs from zero up to a programmable period value and then wraps back to zero. Each period match produces a one-cycle trigger pulse, and one cycle later it sets a sticky interrupt flag.

A gated mode counts prescaled system clocks only while the pin is high. In that mode the flag is raised when the pin falls, so software can measure pulse widths. A stop-in-idle control freezes counting while the idle input is asserted. Software reaches the count, period, control and flag-clear registers through a simple write strobe with a combinational read port.

Top module: `gated_period_timer`

## Requirements
- R1: After reset the count reads 0x0000, the period reads 0xFFFF, the control word reads 0x0000 and the flag is low. Address 0 is count, 1 is period, 2 is control and 3 is flag (read bit 0). Control bits are enable at 15, stop-in-idle at 13, gate at 6, prescale select at 5:4 and external source at 1. All other control bits read back as zero.
- R2: Prescale select 00, 01, 10 and 11 divide the count source by 1, 8, 64 and 256. With a divide of 256, the first increment lands exactly 256 source events after enabling.
- R3: The prescaler restarts from zero on any write to the count or control register, and while enable is low. After a count write, the next increment comes a full prescale interval later.
- R4: In timer mode (source 0, gate 0) with enable set, the count rises by one per prescaled tick. A tick taken while the count equals the period loads zero. While enable is low, the count holds.
- R5: When a tick brings the count to the period, trigOut is high for exactly that one cycle. The flag rises on the following clock edge and stays high until any write to address 3.
- R6: After enabling from count zero, the first flag comes after PR ticks, and each later flag comes after PR+1 ticks.
- R7: A period value of zero never raises the trigger pulse and never sets the flag in timer or counter mode.
- R8: In gated mode (source 0, gate 1), the count advances only while the synchronized pin is high. The flag is set on the synchronized falling edge of the pin rather than on a period match.
- R9: With the external source selected, the gate bit has no effect. The count advances once per synchronized rising edge of the pin, after prescaling.
- R10: With stop-in-idle set, the count freezes while idleIn is high and resumes when it falls. With stop-in-idle clear, idleIn has no effect.
- R11: A write to the count register loads the written value and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | External count or gate pin, asynchronous |
| idleIn | input | 1 | Idle-mode indication |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data for busAddr |
| irqFlag | output | 1 | Sticky interrupt flag |
| trigOut | output | 1 | One-cycle period-match pulse |

## Verification
Timer mode runs with a small period so that the first and second flag intervals can be timed edge by edge. This separates a PR-tick first period from the PR+1 spacing that follows, and it also shows that a flag clear holds until the next match. Divide-by-8 and divide-by-256 runs, with a count write in the middle, show the exact tick position and whether the prescaler restarts. A single long pin pulse in gated mode checks that the count equals the high time and that the falling edge flags. A pulse train in external mode, with the gate bit also set, checks wrap and double matching on edges alone. Idle toggling with stop-in-idle set and then clear separates freezing from free running.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int CTRL_W   = 16;
  localparam int PS_W     = 8;
  localparam int EN_BIT   = 15;
  localparam int IDLE_BIT = 13;
  localparam int GATE_BIT = 6;
  localparam int PS_LO    = 4;
  localparam int SRC_BIT  = 1;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hA072;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  typedef struct packed {
    logic tick;
    logic cntLoad;
    logic perLoad;
    logic flagClr;
    logic gateFall;
    logic gatedMode;
  } strobe_t;

  function automatic logic [PS_W-1:0] psLimit(input logic [1:0] sel);
    case (sel)
      2'd0:    psLimit = 8'd0;
      2'd1:    psLimit = 8'd7;
      2'd2:    psLimit = 8'd63;
      default: psLimit = 8'd255;
    endcase
  endfunction
endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              idleIn,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [CTRL_W-1:0] busWData,
  output logic [CTRL_W-1:0] ctrlQ,
  output strobe_t           strb
);
  logic [SYNC_STAGES:0] syncQ;
  logic pinS, pinD;
  logic [PS_W-1:0] psCnt, psLim;
  logic enable, run, extMode, gated, srcEvent, cntWr, ctrlWr, psClr, atLimit;

  // synchronizer plus one delay stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], pinIn};
  end
  assign pinS = syncQ[SYNC_STAGES-1];
  assign pinD = syncQ[SYNC_STAGES];

  assign cntWr   = busWr && (busAddr == ADDR_COUNT);
  assign ctrlWr  = busWr && (busAddr == ADDR_CTRL);
  assign enable  = ctrlQ[EN_BIT];
  assign run     = enable && !(ctrlQ[IDLE_BIT] && idleIn);
  assign extMode = ctrlQ[SRC_BIT];
  assign gated   = !extMode && ctrlQ[GATE_BIT];
  assign psLim   = psLimit(ctrlQ[PS_LO+1:PS_LO]);
  assign atLimit = (psCnt == psLim);
  assign psClr   = cntWr || ctrlWr || !enable;

  always_comb begin
    if (extMode)    srcEvent = run && pinS && !pinD;
    else if (gated) srcEvent = run && pinS;
    else            srcEvent = run;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= busWData & CTRL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN || psClr) psCnt <= '0;
    else if (srcEvent)  psCnt <= atLimit ? '0 : psCnt + 1'b1;
  end

  always_comb begin
    strb.tick      = srcEvent && atLimit && !cntWr && !ctrlWr;
    strb.cntLoad   = cntWr;
    strb.perLoad   = busWr && (busAddr == ADDR_PERIOD);
    strb.flagClr   = busWr && (busAddr == ADDR_FLAG);
    strb.gateFall  = run && gated && pinD && !pinS;
    strb.gatedMode = gated;
  end
endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] wData,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] periodQ,
  output logic             flagQ,
  output logic             trigQ
);
  logic [CNT_W-1:0] nextCnt;
  logic flagSet;

  assign nextCnt = (countQ == periodQ) ? '0 : countQ + 1'b1;
  assign flagSet = strb.gatedMode ? strb.gateFall : trigQ;

  always_ff @(posedge clk) begin
    if (!rstN)             countQ <= '0;
    else if (strb.cntLoad) countQ <= wData;
    else if (strb.tick)    countQ <= nextCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             periodQ <= '1;
    else if (strb.perLoad) periodQ <= wData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigQ <= 1'b0;
    else       trigQ <= strb.tick && !strb.cntLoad && (periodQ != '0) && (nextCnt == periodQ);
  end

  // set wins over a simultaneous clear so no event is lost
  always_ff @(posedge clk) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (flagSet)      flagQ <= 1'b1;
    else if (strb.flagClr) flagQ <= 1'b0;
  end
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
  import ptmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinIn,
  input  logic        idleIn,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [15:0] busWData,
  output logic [15:0] busRData,
  output logic        irqFlag,
  output logic        trigOut
);
  strobe_t strb;
  logic [CTRL_W-1:0] ctrlQ;
  logic [15:0] countQ, periodQ;

  ptmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .idleIn(idleIn),
    .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .ctrlQ(ctrlQ), .strb(strb)
  );

  ptmr_datapath #(.CNT_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(busWData),
    .countQ(countQ), .periodQ(periodQ), .flagQ(irqFlag), .trigQ(trigOut)
  );

  always_comb begin
    case (busAddr)
      ADDR_COUNT:  busRData = countQ;
      ADDR_PERIOD: busRData = periodQ;
      ADDR_CTRL:   busRData = ctrlQ;
      default:     busRData = {15'd0, irqFlag};
    endcase
  end
endmodule

// File: rtl/gated_period_timer_chk.sv
module gated_period_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] countQ,
  input logic [15:0] periodQ,
  input logic [15:0] ctrlQ,
  input logic        idleIn,
  input logic        busWr,
  input logic [1:0]  busAddr,
  input logic        irqFlag,
  input logic        trigOut
);
  // R5
  trig_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut && !(ctrlQ[6] && !ctrlQ[1]) |=> irqFlag);

  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> ($past(trigOut) || $past(ctrlQ[6] && !ctrlQ[1])));

  // R7
  zero_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodQ == 16'd0) && $stable(periodQ) |-> !trigOut);

  // R4
  trig_at_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut && $stable(periodQ) |-> countQ == periodQ);

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[15] && !(busWr && busAddr == 2'd0) |=> $stable(countQ));

  // R10
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[13] && idleIn && !(busWr && busAddr == 2'd0) |=> $stable(countQ));
endmodule

bind gated_period_timer gated_period_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .countQ(countQ), .periodQ(periodQ), .ctrlQ(ctrlQ),
  .idleIn(idleIn), .busWr(busWr), .busAddr(busAddr), .irqFlag(irqFlag),
  .trigOut(trigOut)
);

// File: tb/gated_period_timer_test.sv
module gated_period_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b0;
  logic idleIn = 1'b0;
  logic busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [15:0] busWData = 16'd0;
  logic [15:0] busRData;
  logic irqFlag, trigOut;

  int nChecks = 0;
  int nFails = 0;
  int trigCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    string       tag;
    logic [15:0] exp;
    logic [15:0] act;
  } item_t;
  item_t sbQ[$];

  always #10 clk = ~clk;

  gated_period_timer uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .idleIn(idleIn), .busWr(busWr),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .irqFlag(irqFlag), .trigOut(trigOut)
  );

  always @(negedge clk) if (rstN && trigOut) trigCnt++;

  // monitor: pops scoreboard items and compares
  always @(negedge clk) begin
    #3;
    while (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      nChecks++;
      if (it.act !== it.exp) begin
        nFails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, it.act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic chk(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    busAddr = a;
    #1;
    it.tag = tag; it.exp = e; it.act = busRData;
    sbQ.push_back(it);
  endtask

  task automatic chkTrig(input int e, input string tag);
    item_t it;
    #1;
    it.tag = tag; it.exp = 16'(e); it.act = 16'(trigCnt);
    sbQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chk(2'd0, 16'h0000, "R1 count reset");
    chk(2'd1, 16'hFFFF, "R1 period reset");
    chk(2'd2, 16'h0000, "R1 control reset");
    chk(2'd3, 16'h0000, "R1 flag reset");
    wr(2'd2, 16'h5F8D);
    chk(2'd2, 16'h0000, "R1 unused control bits");
    wr(2'd2, 16'h2072);
    chk(2'd2, 16'h2072, "R1 control readback");
    wr(2'd2, 16'h0000);

    // R4 R5 R6 timer mode, period 4
    wr(2'd1, 16'd4);
    wr(2'd2, 16'h8000);
    step(3);
    chk(2'd0, 16'd3, "R4 count after 3 ticks");
    chk(2'd3, 16'd0, "R6 no flag before PR ticks");
    step(1);
    chk(2'd0, 16'd4, "R4 count reaches period");
    chk(2'd3, 16'd0, "R5 flag one cycle after match");
    step(1);
    chk(2'd0, 16'd0, "R4 wrap to zero");
    chk(2'd3, 16'd1, "R6 first flag after PR ticks");
    wr(2'd3, 16'd0);
    step(1);
    chk(2'd3, 16'd0, "R5 flag cleared by write");
    chk(2'd0, 16'd3, "R4 count after clear");
    step(1);
    chk(2'd3, 16'd0, "R6 no flag at PR ticks later");
    step(1);
    chk(2'd3, 16'd1, "R6 second flag after PR+1 ticks");
    chkTrig(2, "R5 trigger pulses");

    // R2 R3 R11 divide by 8 and count write
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd100);
    wr(2'd2, 16'h8010);
    step(7);
    chk(2'd0, 16'd0, "R2 div8 before tick");
    step(1);
    chk(2'd0, 16'd1, "R2 div8 tick");
    wr(2'd0, 16'd5);
    chk(2'd0, 16'd5, "R11 count load");
    step(7);
    chk(2'd0, 16'd5, "R3 prescaler cleared by count write");
    step(1);
    chk(2'd0, 16'd6, "R3 tick full interval after write");

    // R2 divide by 256
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h8030);
    step(255);
    chk(2'd0, 16'd0, "R2 div256 before tick");
    step(1);
    chk(2'd0, 16'd1, "R2 div256 tick");

    // R10 stop in idle
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd0);
    idleIn = 1'b1;
    wr(2'd2, 16'hA000);
    step(6);
    chk(2'd0, 16'd0, "R10 frozen in idle");
    idleIn = 1'b0;
    step(5);
    chk(2'd0, 16'd5, "R10 resumes after idle");
    idleIn = 1'b1;
    wr(2'd2, 16'h8000);
    step(4);
    chk(2'd0, 16'd9, "R10 idle ignored when stop-in-idle clear");
    idleIn = 1'b0;

    // R7 zero period
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd3, 16'd0);
    wr(2'd2, 16'h8000);
    step(20);
    chk(2'd3, 16'd0, "R7 zero period no flag");
    chk(2'd0, 16'd0, "R7 zero period count");
    chkTrig(2, "R7 zero period no trigger");

    // R8 gated mode
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'd100);
    wr(2'd0, 16'd0);
    wr(2'd3, 16'd0);
    wr(2'd2, 16'h8040);
    chk(2'd3, 16'd0, "R8 flag low before gate");
    pinIn = 1'b1;
    step(10);
    pinIn = 1'b0;
    step(5);
    chk(2'd0, 16'd10, "R8 gated count equals high time");
    chk(2'd3, 16'd1, "R8 flag on gate fall");

    // R9 external source, gate bit ignored
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd3);
    wr(2'd3, 16'd0);
    wr(2'd2, 16'h8042);
    for (int i = 0; i < 7; i++) begin
      pinIn = 1'b1;
      step(3);
      pinIn = 1'b0;
      step(3);
    end
    step(5);
    chk(2'd0, 16'd3, "R9 external edge count with wrap");
    chk(2'd3, 16'd1, "R9 flag from period match");
    chkTrig(4, "R9 two matches");

    step(3);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule